// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block performs the memory side of a subroutine call, a subroutine return and a software trap for a small 32-bit processor core. The core hands over its current frame pointer, stack pointer, program counter, an operand (the call target or the trap number), the trap handler address and an operation code. The sequencer then issues the word writes or reads that the operation needs, one at a time over a valid/ready memory port. When every result field is final it pulses `done` for one cycle and presents the new frame pointer, stack pointer and next program counter.

Every frame it builds has three word slots below the incoming stack pointer. The top slot is reserved for a static chain and is never written. The middle slot takes the return address, and the lowest slot takes the caller's frame pointer. The frame pointer and the stack pointer both end up at the lowest slot. A return undoes this from the frame pointer alone. A trap always reports a fixed cause code together with its trap number. Only the all-ones trap number builds a frame and enters a handler. Any other trap number falls through to the next instruction.

The block accepts one operation at a time. Decoding, the register file and the memory are outside it.

Top module: `frame_seq`

## Requirements
- R1: Operation codes on `op_in`: 0 = absolute call, 1 = register call, 2 = return, 3 = trap. An absolute call writes the return address `pc_in + 6` to `sp_in - 8` as its first memory access. The slot at `sp_in - 4` is left untouched.
- R2: The second access of any frame-building operation writes `fp_in` to `sp_in - 12`. No third access follows.
- R3: After a call, `fp_out` and `sp_out` both equal `sp_in - 12`, and `pc_out` equals `target_in`.
- R4: A register call pushes the return address `pc_in + 2` instead of `pc_in + 6`.
- R5: A return makes exactly two reads, in this order. It first reads `fp_in`, and that word becomes `fp_out`. It then reads `fp_in + 4`, and that word becomes `pc_out`.
- R6: After a return, `sp_out` equals `fp_in + 12`.
- R7: A trap whose number (`target_in`) is all ones builds the same frame as an absolute call, with return address `pc_in + 6`. Its `pc_out` is `handler_in`.
- R8: Every trap raises `trap_rec` in its `done` cycle, with `trap_cause` = 3 and `trap_num` = the trap number. Any other trap number makes no memory access, leaves `fp_out` = `fp_in` and `sp_out` = `sp_in`, and sets `pc_out` = `pc_in + 6`.
- R9: `mem_valid` is raised for one access at a time. While it waits for `mem_ready`, the access direction, address and write data hold steady.
- R10: `done` lasts exactly one cycle. It is followed by an idle cycle with `busy` low.
- R11: A `start` that arrives while `busy` is high is ignored. The operation in progress keeps its accesses and results, and no second operation follows.
- R12: After reset, `busy`, `done`, `mem_valid` and `trap_rec` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation, accepted only while idle |
| op_in | input | 2 | Operation code (0 abs call, 1 reg call, 2 return, 3 trap) |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| pc_in | input | 32 | Address of the current instruction |
| target_in | input | 32 | Call target, or trap number for a trap |
| handler_in | input | 32 | Trap handler address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fp_out | output | 32 | New frame pointer, valid with done |
| sp_out | output | 32 | New stack pointer, valid with done |
| pc_out | output | 32 | Next program counter, valid with done |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| trap_rec | output | 1 | Trap record strobe, in the done cycle of a trap |
| trap_cause | output | 32 | Cause code to record (3) |
| trap_num | output | 32 | Trap number to record |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4-byte slots, and return-address steps of 6 and 2 bytes. These values put the exact slot addresses `sp - 8`, `sp - 12` and `fp + 4` within reach of fixed expected values. The memory model answers after zero to three wait cycles. This exercises the rule that a pending request must hold steady, and it lets a second `start` land in the middle of a call. A call followed by a return through the same memory checks that the frame written by one operation is read back correctly by the other.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_RETURN   = 2'd2,
    OP_TRAP     = 2'd3
  } fs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_RA = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_POP_FP  = 3'd3,
    ST_POP_PC  = 3'd4,
    ST_FINISH  = 3'd5
  } fs_state_e;
endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  fs_op_e    op,
  input  logic      frame_trap,
  input  logic      xfer_done,
  output fs_state_e state,
  output logic      accept,
  output logic      busy,
  output logic      done
);
  fs_state_e state_nx;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FINISH);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) begin
        unique case (op)
          OP_CALL_ABS, OP_CALL_REG: state_nx = ST_PUSH_RA;
          OP_RETURN:                state_nx = ST_POP_FP;
          OP_TRAP:                  state_nx = frame_trap ? ST_PUSH_RA : ST_FINISH;
          default:                  state_nx = ST_IDLE;
        endcase
      end
      ST_PUSH_RA: if (xfer_done) state_nx = ST_PUSH_FP;
      ST_PUSH_FP: if (xfer_done) state_nx = ST_FINISH;
      ST_POP_FP:  if (xfer_done) state_nx = ST_POP_PC;
      ST_POP_PC:  if (xfer_done) state_nx = ST_FINISH;
      ST_FINISH:  state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/fs_access.sv
module fs_access
  import frame_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SLOT_BYTES = 4
) (
  input  fs_state_e        state,
  input  logic [XLEN-1:0]  base_fp,
  input  logic [XLEN-1:0]  base_sp,
  input  logic [XLEN-1:0]  ret_addr,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata
);
  localparam logic [XLEN-1:0] SLOT = XLEN'(SLOT_BYTES);

  // slot k below the stack pointer (k = 1 is the static-chain slot)
  function automatic logic [XLEN-1:0] slot_below(input logic [XLEN-1:0] sp, input int k);
    return sp - (SLOT * XLEN'(k));
  endfunction

  function automatic logic [XLEN-1:0] slot_above(input logic [XLEN-1:0] fp, input int k);
    return fp + (SLOT * XLEN'(k));
  endfunction

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_RA: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_below(base_sp, 2);
        mem_wdata = ret_addr;
      end
      ST_PUSH_FP: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_below(base_sp, 3);
        mem_wdata = base_fp;
      end
      ST_POP_FP: begin
        mem_valid = 1'b1;
        mem_addr  = slot_above(base_fp, 0);
      end
      ST_POP_PC: begin
        mem_valid = 1'b1;
        mem_addr  = slot_above(base_fp, 1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fs_result.sv
module fs_result
  import frame_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SLOT_BYTES = 4,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  fs_op_e           op,
  input  logic             frame_trap,
  input  logic [XLEN-1:0]  fp_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  target_in,
  input  logic [XLEN-1:0]  handler_in,
  input  fs_state_e        state,
  input  logic             xfer_done,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  base_fp,
  output logic [XLEN-1:0]  base_sp,
  output logic [XLEN-1:0]  ret_addr,
  output fs_op_e           op_q,
  output logic [XLEN-1:0]  trap_num,
  output logic [XLEN-1:0]  fp_out,
  output logic [XLEN-1:0]  sp_out,
  output logic [XLEN-1:0]  pc_out
);
  localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(3 * SLOT_BYTES);

  function automatic logic [XLEN-1:0] return_point(input fs_op_e o, input logic [XLEN-1:0] pc);
    return pc + ((o == OP_CALL_REG) ? XLEN'(SHORT_STEP) : XLEN'(LONG_STEP));
  endfunction

  function automatic logic [XLEN-1:0] frame_top(input logic [XLEN-1:0] sp);
    return sp - FRAME_BYTES;
  endfunction

  function automatic logic [XLEN-1:0] unwound_sp(input logic [XLEN-1:0] fp);
    return fp + FRAME_BYTES;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_fp  <= '0;
      base_sp  <= '0;
      ret_addr <= '0;
      op_q     <= OP_CALL_ABS;
      trap_num <= '0;
      fp_out   <= '0;
      sp_out   <= '0;
      pc_out   <= '0;
    end else if (accept) begin
      base_fp  <= fp_in;
      base_sp  <= sp_in;
      ret_addr <= return_point(op, pc_in);
      op_q     <= op;
      trap_num <= target_in;
      unique case (op)
        OP_CALL_ABS, OP_CALL_REG: begin
          fp_out <= frame_top(sp_in);
          sp_out <= frame_top(sp_in);
          pc_out <= target_in;
        end
        OP_RETURN: begin
          fp_out <= fp_in;
          sp_out <= unwound_sp(fp_in);
          pc_out <= pc_in;
        end
        default: begin
          if (frame_trap) begin
            fp_out <= frame_top(sp_in);
            sp_out <= frame_top(sp_in);
            pc_out <= handler_in;
          end else begin
            fp_out <= fp_in;
            sp_out <= sp_in;
            pc_out <= return_point(OP_TRAP, pc_in);
          end
        end
      endcase
    end else if (xfer_done && state == ST_POP_FP) begin
      fp_out <= mem_rdata;
    end else if (xfer_done && state == ST_POP_PC) begin
      pc_out <= mem_rdata;
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SLOT_BYTES = 4,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2,
  parameter int CAUSE_CODE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_in,
  input  logic [XLEN-1:0]  fp_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  target_in,
  input  logic [XLEN-1:0]  handler_in,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  fp_out,
  output logic [XLEN-1:0]  sp_out,
  output logic [XLEN-1:0]  pc_out,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             trap_rec,
  output logic [XLEN-1:0]  trap_cause,
  output logic [XLEN-1:0]  trap_num
);
  fs_op_e          op_e;
  fs_op_e          op_q;
  fs_state_e       state;
  logic            accept;
  logic            xfer_done;
  logic            frame_trap;
  logic [XLEN-1:0] base_fp;
  logic [XLEN-1:0] base_sp;
  logic [XLEN-1:0] ret_addr;

  assign op_e       = fs_op_e'(op_in);
  assign frame_trap = (op_e == OP_TRAP) && (&target_in);
  assign xfer_done  = mem_valid && mem_ready;

  fs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op_e),
    .frame_trap (frame_trap),
    .xfer_done  (xfer_done),
    .state      (state),
    .accept     (accept),
    .busy       (busy),
    .done       (done)
  );

  fs_access #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_access (
    .state     (state),
    .base_fp   (base_fp),
    .base_sp   (base_sp),
    .ret_addr  (ret_addr),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  fs_result #(
    .XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES),
    .LONG_STEP(LONG_STEP), .SHORT_STEP(SHORT_STEP)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .op         (op_e),
    .frame_trap (frame_trap),
    .fp_in      (fp_in),
    .sp_in      (sp_in),
    .pc_in      (pc_in),
    .target_in  (target_in),
    .handler_in (handler_in),
    .state      (state),
    .xfer_done  (xfer_done),
    .mem_rdata  (mem_rdata),
    .base_fp    (base_fp),
    .base_sp    (base_sp),
    .ret_addr   (ret_addr),
    .op_q       (op_q),
    .trap_num   (trap_num),
    .fp_out     (fp_out),
    .sp_out     (sp_out),
    .pc_out     (pc_out)
  );

  assign trap_rec   = done && (op_q == OP_TRAP);
  assign trap_cause = XLEN'(CAUSE_CODE);
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            trap_rec,
  input logic [XLEN-1:0] trap_cause
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_trap_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_rec |-> (done && trap_cause == XLEN'(3)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !done && !trap_rec));

  assert_no_access_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_frame_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .trap_rec   (trap_rec),
  .trap_cause (trap_cause)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_in = 2'd0;
  logic [31:0] fp_in = '0, sp_in = '0, pc_in = '0, target_in = '0, handler_in = '0;
  logic        busy, done, mem_valid, mem_we, trap_rec;
  logic        mem_ready = 1'b0;
  logic [31:0] fp_out, sp_out, pc_out, mem_addr, mem_wdata, trap_cause, trap_num;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq u_frame_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
    .fp_in(fp_in), .sp_in(sp_in), .pc_in(pc_in), .target_in(target_in),
    .handler_in(handler_in), .busy(busy), .done(done),
    .fp_out(fp_out), .sp_out(sp_out), .pc_out(pc_out),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .trap_rec(trap_rec), .trap_cause(trap_cause), .trap_num(trap_num)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    string       tag;
  } acc_t;

  acc_t        exp_q[$];
  logic [31:0] mem [logic [31:0]];
  int          total = 0;
  int          bad = 0;
  int          lat = 0;
  int          waitcnt = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic expect_acc(input logic we, input logic [31:0] addr, input logic [31:0] wdata, input string tag);
    acc_t a;
    a.we = we; a.addr = addr; a.wdata = wdata; a.tag = tag;
    exp_q.push_back(a);
  endtask

  // memory model and access monitor (scoreboard pop side)
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      waitcnt = 0;
    end else if (mem_valid) begin
      if (waitcnt >= lat) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected access", mem_addr, 32'h0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, {e.tag, " direction"}, {31'd0, mem_we}, {31'd0, e.we});
          check(mem_addr == e.addr, {e.tag, " address"}, mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.wdata, {e.tag, " data"}, mem_wdata, e.wdata);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF;
        mem_ready = 1'b1;
      end else begin
        waitcnt++;
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [31:0] fp, input logic [31:0] sp,
                        input logic [31:0] pc, input logic [31:0] tgt, input logic [31:0] hdl,
                        input int l, input logic poke,
                        input logic [31:0] efp, input logic [31:0] esp, input logic [31:0] epc,
                        input logic etrap, input string tag);
    int cyc;
    lat = l;
    @(negedge clk);
    op_in = op; fp_in = fp; sp_in = sp; pc_in = pc; target_in = tgt; handler_in = hdl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (poke && cyc == 1) begin
        op_in = 2'd2; fp_in = 32'h0000_0400; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      check(1'b0, {tag, " watchdog"}, 32'h0, 32'h1);
    end else begin
      check(fp_out == efp, {tag, " fp_out"}, fp_out, efp);
      check(sp_out == esp, {tag, " sp_out"}, sp_out, esp);
      check(pc_out == epc, {tag, " pc_out"}, pc_out, epc);
      check(trap_rec == etrap, {tag, " R8 trap_rec"}, {31'd0, trap_rec}, {31'd0, etrap});
      if (etrap) begin
        check(trap_cause == 32'd3, {tag, " R8 cause"}, trap_cause, 32'd3);
        check(trap_num == tgt, {tag, " R8 number"}, trap_num, tgt);
      end
      check(exp_q.size() == 0, {tag, " all accesses made"}, exp_q.size(), 32'd0);
    end
    @(negedge clk);
    check(!done && !busy, {tag, " R10 idle after done"}, {30'd0, done, busy}, 32'd0);
    @(negedge clk);
    check(!busy && !mem_valid, {tag, " R11 no second op"}, {30'd0, busy, mem_valid}, 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_valid && !trap_rec, "R12 reset state",
          {28'd0, busy, done, mem_valid, trap_rec}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: absolute call, no wait
    expect_acc(1'b1, 32'h0FF8, 32'h0106, "R1 ra push");
    expect_acc(1'b1, 32'h0FF4, 32'h1010, "R2 fp push");
    run_op(2'd0, 32'h1010, 32'h1000, 32'h0100, 32'h2000, 32'h0, 0, 1'b0,
           32'h0FF4, 32'h0FF4, 32'h2000, 1'b0, "R3 abs call");
    check(!mem.exists(32'h0FFC), "R1 static slot untouched", 32'h0FFC, 32'h0);

    // R6 R5: return through the frame just built
    expect_acc(1'b0, 32'h0FF4, 32'h0, "R5 fp pop");
    expect_acc(1'b0, 32'h0FF8, 32'h0, "R5 pc pop");
    run_op(2'd2, 32'h0FF4, 32'h0FF4, 32'h2040, 32'h0, 32'h0, 1, 1'b0,
           32'h1010, 32'h1000, 32'h0106, 1'b0, "R6 return roundtrip");

    // R4: register call with wait states (R9 holding)
    expect_acc(1'b1, 32'h7FF8, 32'h0302, "R4 ra push");
    expect_acc(1'b1, 32'h7FF4, 32'h8000, "R2 fp push");
    run_op(2'd1, 32'h8000, 32'h8000, 32'h0300, 32'h4444, 32'h0, 2, 1'b0,
           32'h7FF4, 32'h7FF4, 32'h4444, 1'b0, "R4 reg call R9");

    // R5 R6: return from preloaded memory
    mem[32'h0000_5000] = 32'h0000_6000;
    mem[32'h0000_5004] = 32'h0000_0ABC;
    expect_acc(1'b0, 32'h5000, 32'h0, "R5 fp pop");
    expect_acc(1'b0, 32'h5004, 32'h0, "R5 pc pop");
    run_op(2'd2, 32'h5000, 32'h4F00, 32'h0, 32'h0, 32'h0, 3, 1'b0,
           32'h6000, 32'h500C, 32'h0ABC, 1'b0, "R5 R6 return");

    // R7: frame-building trap
    expect_acc(1'b1, 32'h2FF8, 32'h0206, "R7 ra push");
    expect_acc(1'b1, 32'h2FF4, 32'h3100, "R7 fp push");
    run_op(2'd3, 32'h3100, 32'h3000, 32'h0200, 32'hFFFF_FFFF, 32'h9000, 1, 1'b0,
           32'h2FF4, 32'h2FF4, 32'h9000, 1'b1, "R7 frame trap");

    // R8: plain trap, no access
    run_op(2'd3, 32'h3100, 32'h3000, 32'h0200, 32'h0000_0005, 32'h9000, 0, 1'b0,
           32'h3100, 32'h3000, 32'h0206, 1'b1, "R8 plain trap");

    // R11: second start while busy is ignored
    expect_acc(1'b1, 32'h1FF8, 32'h0506, "R11 ra push");
    expect_acc(1'b1, 32'h1FF4, 32'h2222, "R11 fp push");
    run_op(2'd0, 32'h2222, 32'h2000, 32'h0500, 32'h0777, 32'h0, 3, 1'b1,
           32'h1FF4, 32'h1FF4, 32'h0777, 1'b0, "R11 start while busy");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule